// File: doc/BRIEF.md
# USB Full-Speed Serial Receiver

This block turns the two line levels of a full-speed USB pair into a stream of received bytes. The pair is sampled once per bit time, already synchronised to the core clock. A one-cycle enable marks each sample. The receiver classifies every sample as J, K, single-ended zero or the illegal both-high state. It recovers NRZI-coded bits and locks onto the sync pattern. It strips the stuffed zeros, assembles bytes least significant bit first, and recognises the end-of-packet signature.

A packet is reported through strobes: start when the sync completes, byte valid with the byte on the data port, end after a clean end-of-packet, and error when the packet is abandoned. An error abandons the packet and sends the receiver back to hunting for a sync. The receiver accepts the single surplus bit that hub skew can put in front of the end-of-packet. This covers the case where that surplus bit breaks the stuffing rule. A separate detector watches for a long single-ended zero and holds a bus-reset flag while the condition lasts.

Clock recovery, CRC checking and PID decoding belong to other blocks.

Top module: `usb_fs_rx`

## Requirements
- R1: Line states are decoded with J as dp=1/dn=0, K as dp=0/dn=1, SE0 as both low and SE1 as both high.
- R2: A bit time with the same J/K state as the previous one decodes to 1, and a change decodes to 0. Bytes are assembled with the first received bit in rx_data[0]. rx_data holds the byte while rx_valid pulses.
- R3: After six consecutive decoded 1s (the final 1 of the sync counts), the next bit is a stuffed 0. It is discarded and not placed in the byte.
- R4: If the bit that should be stuffed is a 1 and the bit after it is not SE0, rx_err pulses and the packet is abandoned with no rx_eop.
- R5: rx_sop pulses only after J, then seven alternating 0 bits starting with K, then a repeated K. Any other pattern returns to hunting, with no rx_sop, no data and no error.
- R6: rx_sop, rx_valid, rx_eop and rx_err are each high for exactly one clock, the clock right after the bit-enable edge that caused them.
- R7: One surplus bit before the end-of-packet SE0 is dropped without error. This holds when the bit is a single data bit after a complete byte, and when it is a stuffing violation.
- R8: SE0, SE0, then J pulses rx_eop. If SE0 arrives with between two and seven bits of a byte assembled, rx_err pulses and there is no rx_eop.
- R9: SE1 inside a packet pulses rx_err and abandons the packet.
- R10: bus_reset rises on the RESET_BITS-th consecutive SE0 bit time and falls on the first bit time that is not SE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle pulse marking a line sample |
| dp | input | 1 | Synchronised D+ level |
| dn | input | 1 | Synchronised D- level |
| rx_data | output | DATA_W | Last assembled byte |
| rx_valid | output | 1 | Byte-valid strobe |
| rx_sop | output | 1 | Start-of-packet strobe |
| rx_eop | output | 1 | End-of-packet strobe |
| rx_err | output | 1 | Packet-abort strobe |
| bus_reset | output | 1 | Prolonged SE0 detected (level) |

## Verification
The bound checker enforces several rules on every cycle:
- Each strobe is a one-clock pulse that follows a bit enable.
- The strobes never overlap.
- Start only follows a K sample, and end only follows a J sample.
- The bus-reset flag only rises on an SE0 sample and only falls on a sample that is not SE0.

The data path is left to the bench: NRZI decoding, bit order, stuff removal, the surplus-bit tolerance and partial-byte aborts all depend on the sequence of line states. The bench sweeps every byte value through a packet and drives crafted line sequences for each abort and tolerance case.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

    // Line state encoding: value = {dn, dp}
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } line_t;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SYNC,
        ST_DATA,
        ST_END1,
        ST_END2
    } rx_state_t;

    typedef struct packed {
        logic sop;
        logic valid;
        logic eop;
        logic err;
    } rx_evt_t;

    localparam int SYNC_ZEROS = 7;
    localparam int STUFF_RUN  = 6;
    localparam int ZC_W       = $clog2(SYNC_ZEROS + 1);
    localparam int ONES_W     = $clog2(STUFF_RUN + 1);

    function automatic line_t classify(input logic p, input logic n);
        return line_t'({n, p});
    endfunction

endpackage

// File: rtl/usbrx_line.sv
module usbrx_line
    import usbrx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_en,
    input  logic  dp,
    input  logic  dn,
    output line_t cur,
    output line_t prev,
    output logic  same
);
    line_t prev_q;

    assign cur  = classify(dp, dn);
    assign prev = prev_q;
    assign same = (cur == prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= LN_J;
        end else if (bit_en) begin
            prev_q <= cur;
        end
    end
endmodule

// File: rtl/usbrx_shift.sv
module usbrx_shift #(
    parameter int W  = 8,
    localparam int CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic          bit_in,
    output logic [CW-1:0] count,
    output logic          last,
    output logic [W-1:0]  next_word
);
    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;

    assign next_word = {bit_in, sh_q[W-1:1]};
    assign last      = en && (cnt_q == CW'(W - 1));
    assign count     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (en) begin
            sh_q  <= next_word;
            cnt_q <= last ? '0 : cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/usbrx_busreset.sv
module usbrx_busreset #(
    parameter int RESET_BITS = 120000,
    localparam int RW = $clog2(RESET_BITS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic se0,
    output logic flag
);
    localparam logic [RW-1:0] LIMIT = RW'(RESET_BITS);
    localparam logic [RW-1:0] EDGE  = RW'(RESET_BITS - 1);

    logic [RW-1:0] cnt_q;
    logic          flag_q;

    assign flag = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (bit_en) begin
            if (se0) begin
                if (cnt_q != LIMIT) begin
                    cnt_q <= cnt_q + RW'(1);
                end
                flag_q <= (cnt_q >= EDGE);
            end else begin
                cnt_q  <= '0;
                flag_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/usb_fs_rx.sv
module usb_fs_rx
    import usbrx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int RESET_BITS = 120000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              dp,
    input  logic              dn,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_sop,
    output logic              rx_eop,
    output logic              rx_err,
    output logic              bus_reset
);
    localparam int CNT_W = $clog2(DATA_W);

    line_t ln_cur, ln_prev;
    logic  ln_same;

    rx_state_t         state_q, state_d;
    logic [ZC_W-1:0]   zc_q, zc_d;
    logic [ONES_W-1:0] ones_q, ones_d;
    logic              pend_q, pend_d;
    rx_evt_t           evt_q, evt_d;
    logic [DATA_W-1:0] data_q;

    logic              sh_en, sh_clr, sh_last;
    logic [CNT_W-1:0]  sh_cnt;
    logic [DATA_W-1:0] sh_next;

    usbrx_line u_line (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .dp     (dp),
        .dn     (dn),
        .cur    (ln_cur),
        .prev   (ln_prev),
        .same   (ln_same)
    );

    usbrx_shift #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .clr       (sh_clr),
        .en        (sh_en),
        .bit_in    (ln_same),
        .count     (sh_cnt),
        .last      (sh_last),
        .next_word (sh_next)
    );

    usbrx_busreset #(.RESET_BITS(RESET_BITS)) u_busrst (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .se0    (ln_cur == LN_SE0),
        .flag   (bus_reset)
    );

    always_comb begin
        state_d = state_q;
        zc_d    = zc_q;
        ones_d  = ones_q;
        pend_d  = pend_q;
        evt_d   = '0;
        sh_en   = 1'b0;
        sh_clr  = 1'b0;
        if (bit_en) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (ln_prev == LN_J && ln_cur == LN_K) begin
                        state_d = ST_SYNC;
                        zc_d    = ZC_W'(1);
                    end
                end
                ST_SYNC: begin
                    if (ln_cur == LN_J || ln_cur == LN_K) begin
                        if (!ln_same) begin
                            if (zc_q == ZC_W'(SYNC_ZEROS)) begin
                                state_d = ST_HUNT;
                            end else begin
                                zc_d = zc_q + ZC_W'(1);
                            end
                        end else if (ln_cur == LN_K && zc_q == ZC_W'(SYNC_ZEROS)) begin
                            state_d   = ST_DATA;
                            evt_d.sop = 1'b1;
                            ones_d    = ONES_W'(1);
                            pend_d    = 1'b0;
                            sh_clr    = 1'b1;
                        end else begin
                            state_d = ST_HUNT;
                        end
                    end else begin
                        state_d = ST_HUNT;
                    end
                end
                ST_DATA: begin
                    if (ln_cur == LN_SE0) begin
                        // surplus bit (stuff violation or one stray data bit) is tolerated
                        if (pend_q || sh_cnt <= CNT_W'(1)) begin
                            state_d = ST_END1;
                        end else begin
                            evt_d.err = 1'b1;
                            state_d   = ST_HUNT;
                        end
                    end else if (ln_cur == LN_SE1) begin
                        evt_d.err = 1'b1;
                        state_d   = ST_HUNT;
                    end else if (pend_q) begin
                        evt_d.err = 1'b1;
                        state_d   = ST_HUNT;
                    end else if (ones_q == ONES_W'(STUFF_RUN)) begin
                        if (ln_same) begin
                            pend_d = 1'b1;
                        end else begin
                            ones_d = '0;
                        end
                    end else begin
                        sh_en  = 1'b1;
                        ones_d = ln_same ? ones_q + ONES_W'(1) : '0;
                        if (sh_last) begin
                            evt_d.valid = 1'b1;
                        end
                    end
                end
                ST_END1: begin
                    if (ln_cur == LN_SE0) begin
                        state_d = ST_END2;
                    end else begin
                        evt_d.err = 1'b1;
                        state_d   = ST_HUNT;
                    end
                end
                ST_END2: begin
                    if (ln_cur == LN_J) begin
                        evt_d.eop = 1'b1;
                        state_d   = ST_HUNT;
                    end else if (ln_cur != LN_SE0) begin
                        evt_d.err = 1'b1;
                        state_d   = ST_HUNT;
                    end
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            zc_q    <= '0;
            ones_q  <= '0;
            pend_q  <= 1'b0;
            evt_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            zc_q    <= zc_d;
            ones_q  <= ones_d;
            pend_q  <= pend_d;
            evt_q   <= evt_d;
            if (evt_d.valid) begin
                data_q <= sh_next;
            end
        end
    end

    assign rx_data  = data_q;
    assign rx_valid = evt_q.valid;
    assign rx_sop   = evt_q.sop;
    assign rx_eop   = evt_q.eop;
    assign rx_err   = evt_q.err;
endmodule

// File: rtl/usb_fs_rx_chk.sv
module usb_fs_rx_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic dp,
    input logic dn,
    input logic rx_valid,
    input logic rx_sop,
    input logic rx_eop,
    input logic rx_err,
    input logic bus_reset
);
    assert_strobe_after_enable_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid || rx_sop || rx_eop || rx_err) |-> $past(bit_en));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_eop_single_R6: assert property (@(posedge clk) disable iff (rst)
        rx_eop |=> !rx_eop);

    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_sop, rx_valid, rx_eop, rx_err}));

    assert_eop_on_j_R8: assert property (@(posedge clk) disable iff (rst)
        rx_eop |-> $past(dp && !dn));

    assert_sop_on_k_R5: assert property (@(posedge clk) disable iff (rst)
        rx_sop |-> $past(!dp && dn));

    assert_reset_rise_se0_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_reset) |-> $past(bit_en && !dp && !dn));

    assert_reset_fall_line_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_reset) |-> $past(bit_en && (dp || dn)));
endmodule

bind usb_fs_rx usb_fs_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .dp        (dp),
    .dn        (dn),
    .rx_valid  (rx_valid),
    .rx_sop    (rx_sop),
    .rx_eop    (rx_eop),
    .rx_err    (rx_err),
    .bus_reset (bus_reset)
);

// File: tb/usb_fs_rx_bench.sv
module usb_fs_rx_bench;
    localparam int RB = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic dp = 1'b1;
    logic dn = 1'b0;
    logic [7:0] rx_data;
    logic rx_valid, rx_sop, rx_eop, rx_err, bus_reset;

    always #2.5 clk = ~clk;

    usb_fs_rx #(.DATA_W(8), .RESET_BITS(RB)) u_usb_fs_rx (
        .clk(clk), .rst(rst), .bit_en(bit_en), .dp(dp), .dn(dn),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_sop(rx_sop),
        .rx_eop(rx_eop), .rx_err(rx_err), .bus_reset(bus_reset)
    );

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] cap [0:15];
    int ncap, nsop, neop, nerrev, stray;
    logic lvl = 1'b1;
    int ones = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_cap();
        ncap = 0; nsop = 0; neop = 0; nerrev = 0; stray = 0;
    endtask

    task automatic tick(input logic p, input logic n);
        @(negedge clk);
        dp = p; dn = n; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        if (rx_valid) begin
            if (ncap < 16) cap[ncap] = rx_data;
            ncap++;
        end
        if (rx_sop) nsop++;
        if (rx_eop) neop++;
        if (rx_err) nerrev++;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            if (rx_valid || rx_sop || rx_eop || rx_err) stray++;
        end
    endtask

    task automatic line_j(); lvl = 1'b1; tick(1'b1, 1'b0); endtask
    task automatic se0(); tick(1'b0, 1'b0); endtask
    task automatic se1(); tick(1'b1, 1'b1); endtask
    task automatic idle(input int n); for (int i = 0; i < n; i++) line_j(); endtask

    task automatic raw_bit(input logic b);
        if (!b) lvl = ~lvl;
        tick(lvl, ~lvl);
    endtask

    task automatic data_bit(input logic b);
        raw_bit(b);
        ones = b ? ones + 1 : 0;
        if (ones == 6) begin
            raw_bit(1'b0);
            ones = 0;
        end
    endtask

    task automatic send_sync();
        for (int i = 0; i < 7; i++) raw_bit(1'b0);
        raw_bit(1'b1);
        ones = 1;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) data_bit(v[i]);
    endtask

    task automatic send_eop();
        se0(); se0(); line_j();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] mix [0:4];
        mix[0] = 8'h00; mix[1] = 8'hFF; mix[2] = 8'h7E; mix[3] = 8'h3F; mix[4] = 8'h81;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(!rx_valid && !rx_sop && !rx_eop && !rx_err, "R6", "strobes after reset",
            {rx_valid, rx_sop, rx_eop, rx_err}, 0);
        chk(bus_reset == 1'b0, "R10", "bus_reset after reset", bus_reset, 0);

        // R1 R2 R3 R8: every byte value in its own packet
        for (int v = 0; v < 256; v++) begin
            clear_cap();
            idle(2); send_sync(); send_byte(8'(v)); send_eop(); idle(1);
            chk(nsop == 1, "R5", "sop count in sweep", nsop, 1);
            chk(ncap == 1 && cap[0] == 8'(v), "R2", "swept byte", (ncap == 1) ? int'(cap[0]) : -ncap, v);
            chk(neop == 1, "R8", "eop count in sweep", neop, 1);
            chk(nerrev == 0, "R3", "no error in sweep", nerrev, 0);
            chk(stray == 0, "R6", "strobe wider than one clock", stray, 0);
        end

        // R3: stuffing-heavy multi-byte packet
        clear_cap();
        idle(2); send_sync();
        for (int i = 0; i < 5; i++) send_byte(mix[i]);
        send_eop(); idle(1);
        chk(ncap == 5, "R3", "byte count multi", ncap, 5);
        for (int i = 0; i < 5; i++)
            chk(cap[i] == mix[i], "R3", "multi byte value", int'(cap[i]), int'(mix[i]));
        chk(neop == 1 && nerrev == 0, "R3", "multi clean end", neop * 10 + nerrev, 10);

        // R4: seven ones then data -> error, no eop
        clear_cap();
        idle(2); send_sync();
        for (int i = 0; i < 7; i++) raw_bit(1'b1);
        raw_bit(1'b0); send_eop(); idle(1);
        chk(nerrev == 1, "R4", "stuff error count", nerrev, 1);
        chk(neop == 0 && ncap == 0, "R4", "no eop/data after abort", neop + ncap, 0);

        // R7: stuff violation as the surplus bit before SE0
        clear_cap();
        idle(2); send_sync();
        raw_bit(1'b0); raw_bit(1'b0);
        for (int i = 0; i < 6; i++) raw_bit(1'b1);
        raw_bit(1'b1);
        send_eop(); idle(1);
        chk(ncap == 1 && cap[0] == 8'hFC, "R7", "byte before skew bit", int'(cap[0]), 8'hFC);
        chk(nerrev == 0 && neop == 1, "R7", "skew violation tolerated", nerrev * 10 + neop, 1);

        // R7: one surplus data bit after a complete byte
        clear_cap();
        idle(2); send_sync(); send_byte(8'h5A); raw_bit(1'b0); send_eop(); idle(1);
        chk(ncap == 1 && cap[0] == 8'h5A, "R7", "byte before surplus bit", int'(cap[0]), 8'h5A);
        chk(nerrev == 0 && neop == 1, "R7", "surplus bit tolerated", nerrev * 10 + neop, 1);

        // R8: three bits of a partial byte at SE0 -> error
        clear_cap();
        idle(2); send_sync(); send_byte(8'h11);
        data_bit(1'b1); data_bit(1'b0); data_bit(1'b1);
        send_eop(); idle(1);
        chk(nerrev == 1 && neop == 0, "R8", "partial byte abort", nerrev * 10 + neop, 10);
        chk(ncap == 1 && cap[0] == 8'h11, "R8", "byte before partial", int'(cap[0]), 8'h11);

        // R9 R1: SE1 in packet -> error
        clear_cap();
        idle(2); send_sync(); send_byte(8'h42); se1(); send_eop(); idle(1);
        chk(nerrev == 1 && neop == 0, "R9", "SE1 abort", nerrev * 10 + neop, 10);
        chk(ncap == 1 && cap[0] == 8'h42, "R1", "byte before SE1", int'(cap[0]), 8'h42);

        // R5: short sync -> ignored
        clear_cap();
        idle(2);
        for (int i = 0; i < 5; i++) raw_bit(1'b0);
        raw_bit(1'b1); ones = 1;
        send_byte(8'h55); send_eop(); idle(1);
        chk(nsop == 0 && ncap == 0, "R5", "short sync no packet", nsop + ncap, 0);
        chk(nerrev == 0 && neop == 0, "R5", "short sync silent", nerrev + neop, 0);

        // R10: bus reset threshold
        clear_cap();
        idle(2);
        for (int i = 0; i < RB - 1; i++) se0();
        chk(bus_reset == 1'b0, "R10", "bus_reset one bit early", bus_reset, 0);
        se0();
        chk(bus_reset == 1'b1, "R10", "bus_reset at threshold", bus_reset, 1);
        se0();
        chk(bus_reset == 1'b1, "R10", "bus_reset held", bus_reset, 1);
        line_j();
        chk(bus_reset == 1'b0, "R10", "bus_reset cleared by J", bus_reset, 0);
        chk(nerrev == 0 && neop == 0, "R10", "reset SE0 not a packet", nerrev + neop, 0);

        // recovery after aborts
        clear_cap();
        idle(3); send_sync(); send_byte(8'hA5); send_eop(); idle(1);
        chk(ncap == 1 && cap[0] == 8'hA5 && neop == 1, "R2", "packet after reset", int'(cap[0]), 8'hA5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule